// File: doc/BRIEF.md
# Trap Delegation Mask Registers

This block holds, for one hart that has a supervisor mode, the two machine-level bitmasks that decide which traps skip the machine-mode handler: one mask for synchronous exceptions, one for interrupts. Bit i of the exception mask stands for exception cause code i. The interrupt mask uses the same bit layout as the interrupt-pending register. The trap logic reads both masks continuously from dedicated outputs and makes its own routing decision.

Software reaches the masks over a small CSR bus carrying a request strobe, the current privilege level, address, write enable and write data. The bus returns read data and an illegal-access flag in the same cycle. Every bit is write-any, read-legal. A parameter lists which causes the implementation lets software delegate. Two exception positions, the machine-mode environment call and the double trap, are always held at zero. No bit can ever be stuck at one. So writing all ones and reading back reports exactly the delegatable set. On 32-bit configurations the upper half of the 64-bit exception mask sits behind a separate companion address.

A hart built without supervisor mode has no such registers. Any access to their addresses is then flagged illegal.

Top module: `trap_deleg_csr`

## Requirements
- R1: Reset clears both masks, so `exc_deleg` and `int_deleg` read zero in the cycle after reset and every trap starts out routed to machine mode.
- R2: A machine-mode write to address 0x302 stores write data ANDed with the legal exception set. In a 32-bit hart this address covers mask bits 31:0. A read of 0x302 in the same configuration returns those bits.
- R3: Exception mask bits 11 and 16 always read zero and ignore writes, even when the writable-bit parameter enables them.
- R4: A machine-mode write to address 0x303 stores write data ANDed with the writable interrupt set, and a read returns the stored value. The default set is bits 1, 5 and 9, so writing all ones reads back 0x222.
- R5: In a 32-bit hart, address 0x312 reads and writes exception mask bits 63:32, with the same legalization rules.
- R6: A write to one half of the exception mask leaves the other half unchanged.
- R7: An access to 0x302, 0x303 or 0x312 at a privilege level below machine raises `csr_illegal` in the same cycle, returns zero read data and changes no mask. Privilege codes are 0 user, 1 supervisor, 3 machine.
- R8: A legal write appears on `exc_deleg` or `int_deleg` from the first clock edge after the write cycle.
- R9: An access to any other address raises no illegal flag, returns zero and leaves both masks unchanged.
- R10: With supervisor mode absent (`HAS_SMODE` = 0), every access to the three addresses raises `csr_illegal`, and both masks stay zero.
- R11: A read without write enable leaves both masks unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_req | input | 1 | A CSR access is presented this cycle |
| csr_we | input | 1 | The access writes |
| csr_addr | input | 12 | CSR address |
| csr_priv | input | 2 | Privilege of the access (0 U, 1 S, 3 M) |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Read data, zero when not a legal read of this block |
| csr_illegal | output | 1 | Access to this block's addresses is not permitted |
| exc_deleg | output | 64 | Legalized exception delegation mask |
| int_deleg | output | XLEN | Legalized interrupt delegation mask |

## Verification
Read data and the illegal flag are combinational, so they are due in the same cycle as the request. The mask outputs take a write at the next rising edge. The driver applies each access 1 ns after a rising edge. It queues the read data and flag expected for that cycle, together with the mask values that the earlier accesses should have left. The monitor pops and compares one item at the following falling edge. A write's effect is therefore seen in the item after it, never in its own.

// File: rtl/trap_deleg_pkg.sv
package trap_deleg_pkg;

    localparam logic [11:0] ADDR_EXC_LO = 12'h302;
    localparam logic [11:0] ADDR_INT    = 12'h303;
    localparam logic [11:0] ADDR_EXC_HI = 12'h312;

    localparam int EXC_BIT_ECALL_M = 11;
    localparam int EXC_BIT_DBLTRAP = 16;

    typedef enum logic [1:0] {
        PRIV_U = 2'b00,
        PRIV_S = 2'b01,
        PRIV_M = 2'b11
    } priv_e;

    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_EXC_LO = 2'd1,
        SEL_INT    = 2'd2,
        SEL_EXC_HI = 2'd3
    } sel_e;

    typedef struct packed {
        sel_e sel;
        logic illegal;
        logic wr_en;
    } dec_s;

    function automatic logic [63:0] exc_legal_set(input logic [63:0] wmask);
        logic [63:0] pinned;
        pinned = (64'h1 << EXC_BIT_ECALL_M) | (64'h1 << EXC_BIT_DBLTRAP);
        return wmask & ~pinned;
    endfunction

    function automatic logic is_deleg_addr(input logic [11:0] a);
        return (a == ADDR_EXC_LO) || (a == ADDR_INT) || (a == ADDR_EXC_HI);
    endfunction

endpackage

// File: rtl/deleg_csr_decode.sv
module deleg_csr_decode
    import trap_deleg_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter bit HAS_SMODE = 1'b1
) (
    input  logic        csr_req,
    input  logic        csr_we,
    input  logic [11:0] csr_addr,
    input  logic [1:0]  csr_priv,
    output dec_s        dec
);

    localparam bit HAS_HI_ALIAS = (XLEN == 32);

    sel_e raw_sel;
    logic ours;
    logic exists;

    always_comb begin
        unique case (csr_addr)
            ADDR_EXC_LO: raw_sel = SEL_EXC_LO;
            ADDR_INT:    raw_sel = SEL_INT;
            ADDR_EXC_HI: raw_sel = SEL_EXC_HI;
            default:     raw_sel = SEL_NONE;
        endcase
        ours   = csr_req && is_deleg_addr(csr_addr);
        exists = HAS_SMODE && !((raw_sel == SEL_EXC_HI) && !HAS_HI_ALIAS);

        dec.illegal = ours && (!exists || (csr_priv != PRIV_M));
        dec.sel     = (ours && !dec.illegal) ? raw_sel : SEL_NONE;
        dec.wr_en   = ours && !dec.illegal && csr_we;
    end

endmodule

// File: rtl/deleg_warl_reg.sv
module deleg_warl_reg #(
    parameter int             W     = 32,
    parameter logic [W-1:0]   LEGAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (wr_en) begin
            q <= wdata & LEGAL;
        end
    end

endmodule

// File: rtl/trap_deleg_csr.sv
module trap_deleg_csr
    import trap_deleg_pkg::*;
#(
    parameter int          XLEN      = 32,
    parameter bit          HAS_SMODE = 1'b1,
    parameter logic [63:0] EXC_WMASK = 64'h0000_0000_0004_B7FF,
    parameter logic [63:0] INT_WMASK = 64'h0000_0000_0000_0222
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            csr_req,
    input  logic            csr_we,
    input  logic [11:0]     csr_addr,
    input  logic [1:0]      csr_priv,
    input  logic [XLEN-1:0] csr_wdata,
    output logic [XLEN-1:0] csr_rdata,
    output logic            csr_illegal,
    output logic [63:0]     exc_deleg,
    output logic [XLEN-1:0] int_deleg
);

    localparam logic [63:0]     EXC_LEGAL = HAS_SMODE ? exc_legal_set(EXC_WMASK) : 64'h0;
    localparam logic [XLEN-1:0] INT_LEGAL = HAS_SMODE ? INT_WMASK[XLEN-1:0] : '0;

    dec_s dec;

    deleg_csr_decode #(
        .XLEN      (XLEN),
        .HAS_SMODE (HAS_SMODE)
    ) u_decode (
        .csr_req  (csr_req),
        .csr_we   (csr_we),
        .csr_addr (csr_addr),
        .csr_priv (csr_priv),
        .dec      (dec)
    );

    logic [63:0] exc_q;

    generate
        if (XLEN == 32) begin : g_split
            logic [31:0] lo_q;
            logic [31:0] hi_q;

            deleg_warl_reg #(.W(32), .LEGAL(EXC_LEGAL[31:0])) u_exc_lo (
                .clk   (clk),
                .rst   (rst),
                .wr_en (dec.wr_en && (dec.sel == SEL_EXC_LO)),
                .wdata (csr_wdata),
                .q     (lo_q)
            );

            deleg_warl_reg #(.W(32), .LEGAL(EXC_LEGAL[63:32])) u_exc_hi (
                .clk   (clk),
                .rst   (rst),
                .wr_en (dec.wr_en && (dec.sel == SEL_EXC_HI)),
                .wdata (csr_wdata),
                .q     (hi_q)
            );

            assign exc_q = {hi_q, lo_q};
        end else begin : g_full
            deleg_warl_reg #(.W(64), .LEGAL(EXC_LEGAL)) u_exc (
                .clk   (clk),
                .rst   (rst),
                .wr_en (dec.wr_en && (dec.sel == SEL_EXC_LO)),
                .wdata (64'(csr_wdata)),
                .q     (exc_q)
            );
        end
    endgenerate

    logic [XLEN-1:0] int_q;

    deleg_warl_reg #(.W(XLEN), .LEGAL(INT_LEGAL)) u_int (
        .clk   (clk),
        .rst   (rst),
        .wr_en (dec.wr_en && (dec.sel == SEL_INT)),
        .wdata (csr_wdata),
        .q     (int_q)
    );

    always_comb begin
        unique case (dec.sel)
            SEL_EXC_LO: csr_rdata = exc_q[XLEN-1:0];
            SEL_EXC_HI: csr_rdata = XLEN'(exc_q[63:32]);
            SEL_INT:    csr_rdata = int_q;
            default:    csr_rdata = '0;
        endcase
    end

    assign csr_illegal = dec.illegal;
    assign exc_deleg   = exc_q;
    assign int_deleg   = int_q;

endmodule

// File: rtl/trap_deleg_chk.sv
module trap_deleg_chk
    import trap_deleg_pkg::*;
#(
    parameter int          XLEN      = 32,
    parameter bit          HAS_SMODE = 1'b1,
    parameter logic [63:0] EXC_WMASK = 64'h0
) (
    input logic            clk,
    input logic            rst,
    input logic            csr_req,
    input logic            csr_we,
    input logic [11:0]     csr_addr,
    input logic [1:0]      csr_priv,
    input logic [XLEN-1:0] csr_rdata,
    input logic            csr_illegal,
    input logic [63:0]     exc_deleg,
    input logic [XLEN-1:0] int_deleg
);

    logic mine;
    assign mine = csr_req && is_deleg_addr(csr_addr);

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (exc_deleg == 64'h0) && (int_deleg == '0));

    assert_stays_legal_R2: assert property (@(posedge clk) disable iff (rst)
        (exc_deleg & ~EXC_WMASK) == 64'h0);

    assert_pinned_zero_R3: assert property (@(posedge clk) disable iff (rst)
        !exc_deleg[11] && !exc_deleg[16]);

    assert_low_priv_flag_R7: assert property (@(posedge clk) disable iff (rst)
        (mine && (csr_priv != 2'b11)) |-> (csr_illegal && (csr_rdata == '0)));

    assert_low_priv_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (mine && (csr_priv != 2'b11)) |=> ($stable(exc_deleg) && $stable(int_deleg)));

    assert_foreign_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (csr_req && !is_deleg_addr(csr_addr)) |-> (!csr_illegal && (csr_rdata == '0)));

    assert_no_write_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !(csr_req && csr_we) |=> ($stable(exc_deleg) && $stable(int_deleg)));

    generate
        if (XLEN == 32) begin : g_half
            assert_hi_keeps_lo_R6: assert property (@(posedge clk) disable iff (rst)
                (csr_req && (csr_addr == 12'h312)) |=> $stable(exc_deleg[31:0]));
        end
        if (!HAS_SMODE) begin : g_absent
            assert_absent_illegal_R10: assert property (@(posedge clk) disable iff (rst)
                mine |-> csr_illegal);
        end
    endgenerate

endmodule

bind trap_deleg_csr trap_deleg_chk #(
    .XLEN      (XLEN),
    .HAS_SMODE (HAS_SMODE),
    .EXC_WMASK (EXC_WMASK)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .csr_req     (csr_req),
    .csr_we      (csr_we),
    .csr_addr    (csr_addr),
    .csr_priv    (csr_priv),
    .csr_rdata   (csr_rdata),
    .csr_illegal (csr_illegal),
    .exc_deleg   (exc_deleg),
    .int_deleg   (int_deleg)
);

// File: tb/trap_deleg_csr_bench.sv
module trap_deleg_csr_bench;

    localparam logic [63:0] WMASK  = 64'h0000_0005_0005_BFFF;
    localparam logic [63:0] EXC_OK = 64'h0000_0005_0004_B7FF;
    localparam logic [31:0] INT_OK = 32'h0000_0222;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        csr_req = 1'b0, csr_we = 1'b0;
    logic [11:0] csr_addr = '0;
    logic [1:0]  csr_priv = 2'b11;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        csr_illegal;
    logic [63:0] exc_deleg;
    logic [31:0] int_deleg;

    logic        n_req = 1'b0, n_we = 1'b0;
    logic [11:0] n_addr = '0;
    logic [31:0] n_wdata = '0;
    logic [31:0] n_rdata;
    logic        n_illegal;
    logic [63:0] n_exc;
    logic [31:0] n_int;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    trap_deleg_csr #(.XLEN(32), .HAS_SMODE(1'b1), .EXC_WMASK(WMASK)) u_trap_deleg_csr (
        .clk(clk), .rst(rst), .csr_req(csr_req), .csr_we(csr_we), .csr_addr(csr_addr),
        .csr_priv(csr_priv), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .csr_illegal(csr_illegal), .exc_deleg(exc_deleg), .int_deleg(int_deleg)
    );

    trap_deleg_csr #(.XLEN(32), .HAS_SMODE(1'b0)) u_trap_deleg_csr_nos (
        .clk(clk), .rst(rst), .csr_req(n_req), .csr_we(n_we), .csr_addr(n_addr),
        .csr_priv(2'b11), .csr_wdata(n_wdata), .csr_rdata(n_rdata),
        .csr_illegal(n_illegal), .exc_deleg(n_exc), .int_deleg(n_int)
    );

    typedef struct {
        logic [31:0] rdata;
        logic        ill;
        logic [63:0] exc;
        logic [31:0] intv;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    logic [63:0] m_exc = '0;
    logic [31:0] m_int = '0;

    task automatic access(input logic req, input logic we, input logic [11:0] addr,
                          input logic [1:0] priv, input logic [31:0] wd, input string tag);
        exp_t e;
        logic mine, ill;
        @(posedge clk); #1;
        csr_req = req; csr_we = we; csr_addr = addr; csr_priv = priv; csr_wdata = wd;
        mine = req && (addr == 12'h302 || addr == 12'h303 || addr == 12'h312);
        ill  = mine && (priv != 2'b11);
        e.rdata = 32'h0;
        if (mine && !ill) begin
            if (addr == 12'h302) e.rdata = m_exc[31:0];
            if (addr == 12'h312) e.rdata = m_exc[63:32];
            if (addr == 12'h303) e.rdata = m_int;
        end
        e.ill = ill; e.exc = m_exc; e.intv = m_int; e.tag = tag;
        sb.push_back(e);
        if (mine && !ill && we) begin
            if (addr == 12'h302) m_exc[31:0]  = wd & EXC_OK[31:0];
            if (addr == 12'h312) m_exc[63:32] = wd & EXC_OK[63:32];
            if (addr == 12'h303) m_int        = wd & INT_OK;
        end
    endtask

    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (csr_rdata !== e.rdata || csr_illegal !== e.ill ||
                exc_deleg !== e.exc || int_deleg !== e.intv) begin
                errors++;
                $display("FAIL %s: rdata=%h ill=%b exc=%h int=%h expected rdata=%h ill=%b exc=%h int=%h",
                         e.tag, csr_rdata, csr_illegal, exc_deleg, int_deleg,
                         e.rdata, e.ill, e.exc, e.intv);
            end
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    initial begin
        #(20 * 20000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1: reset state
        access(1'b0, 1'b0, 12'h000, 2'b11, 32'h0, "R1 idle after reset");
        access(1'b1, 1'b0, 12'h302, 2'b11, 32'h0, "R1 exc reads zero");
        access(1'b1, 1'b0, 12'h303, 2'b11, 32'h0, "R1 int reads zero");
        // R2 / R3: all-ones probe of low half
        access(1'b1, 1'b1, 12'h302, 2'b11, 32'hFFFF_FFFF, "R2 write ones low");
        access(1'b1, 1'b0, 12'h302, 2'b11, 32'h0, "R2 R3 probe readback low");
        access(1'b1, 1'b0, 12'h312, 2'b11, 32'h0, "R6 high untouched by low write");
        // R5: companion upper half
        access(1'b1, 1'b1, 12'h312, 2'b11, 32'hFFFF_FFFF, "R5 write ones high");
        access(1'b1, 1'b0, 12'h312, 2'b11, 32'h0, "R5 readback high");
        access(1'b1, 1'b0, 12'h302, 2'b11, 32'h0, "R6 low untouched by high write");
        // R4: interrupt mask
        access(1'b1, 1'b1, 12'h303, 2'b11, 32'hFFFF_FFFF, "R4 write ones int");
        access(1'b1, 1'b0, 12'h303, 2'b11, 32'h0, "R4 readback int");
        // R3: pinned bits with a targeted pattern
        access(1'b1, 1'b1, 12'h302, 2'b11, 32'h0001_0801, "R3 write pinned bits");
        access(1'b1, 1'b0, 12'h302, 2'b11, 32'h0, "R3 pinned bits read zero");
        // R7: lower privilege
        access(1'b1, 1'b1, 12'h302, 2'b01, 32'hFFFF_FFFF, "R7 supervisor write");
        access(1'b1, 1'b0, 12'h303, 2'b00, 32'h0, "R7 user read");
        access(1'b1, 1'b1, 12'h312, 2'b00, 32'h0, "R7 user write high");
        access(1'b1, 1'b0, 12'h302, 2'b11, 32'h0, "R7 state unchanged");
        // R9: foreign addresses
        access(1'b1, 1'b1, 12'h300, 2'b11, 32'hFFFF_FFFF, "R9 foreign write");
        access(1'b1, 1'b0, 12'h304, 2'b01, 32'h0, "R9 foreign read low priv");
        access(1'b1, 1'b0, 12'h303, 2'b11, 32'h0, "R9 int unchanged");
        // R11: reads with write data present do not write
        access(1'b1, 1'b0, 12'h302, 2'b11, 32'hDEAD_BEEF, "R11 read with data");
        access(1'b1, 1'b0, 12'h312, 2'b11, 32'h1234_5678, "R11 high unchanged");
        // R8 / R2: patterns, visible on outputs the next cycle
        access(1'b1, 1'b1, 12'h302, 2'b11, 32'hA5A5_A5A5, "R8 pattern write");
        access(1'b1, 1'b1, 12'h303, 2'b11, 32'h0000_0020, "R8 exc out after write");
        access(1'b1, 1'b1, 12'h312, 2'b11, 32'h0000_0004, "R8 int out after write");
        access(1'b0, 1'b0, 12'h000, 2'b11, 32'h0, "R8 high out after write");
        access(1'b1, 1'b1, 12'h302, 2'b11, 32'h5A5A_5A5A, "R2 second pattern");
        access(1'b1, 1'b0, 12'h302, 2'b11, 32'h0, "R2 second readback");
        access(1'b0, 1'b0, 12'h000, 2'b11, 32'h0, "R2 drain");
        // R1: reset in mid-run
        @(posedge clk); #1 rst = 1'b1;
        @(posedge clk); #1 rst = 1'b0;
        m_exc = '0; m_int = '0;
        access(1'b1, 1'b0, 12'h303, 2'b11, 32'h0, "R1 mid-run reset");
        access(1'b0, 1'b0, 12'h000, 2'b11, 32'h0, "R1 drain");
        @(posedge clk);
        // R10: hart without supervisor mode
        #1; n_req = 1'b1; n_we = 1'b1; n_addr = 12'h302; n_wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        chk(n_illegal === 1'b1, "R10 illegal on 0x302", 64'(n_illegal), 64'h1);
        chk(n_rdata === 32'h0, "R10 rdata zero", 64'(n_rdata), 64'h0);
        @(posedge clk); #1; n_addr = 12'h303;
        @(negedge clk);
        chk(n_illegal === 1'b1, "R10 illegal on 0x303", 64'(n_illegal), 64'h1);
        chk(n_exc === 64'h0, "R10 exc stays zero", n_exc, 64'h0);
        @(posedge clk); #1; n_req = 1'b0; n_we = 1'b0;
        @(negedge clk);
        chk(n_int === 32'h0, "R10 int stays zero", 64'(n_int), 64'h0);
        repeat (2) @(posedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule